// File: doc/BRIEF.md
# Reset Line Generator

This peripheral drives a bank of 64 reset outputs. A small register bus controls it. The bus is single-cycle and has an address, a write strobe, write data and read data. Reads are combinational on the current address.

Lines are grouped 32 to a register. Line `n` is bit `n % 32` of the register pair that `n / 32` selects. Writing a 1 into a control bit starts a reset on that line.

Lines behave in one of two ways:

- Most lines are self-clearing. They produce a pulse of fixed length and then release without further writes.
- Two lines are level-held. They stay asserted until a control write puts 0 in their bit.

A status view returns the same line states inverted, so a 0 means "in reset". Line 0 is the system line. While it is active, a system reset request output is raised.

Top module: `reset_gen_unit`

## Requirements
- R1: Control registers decode at offset 0x100 (lines 0–31) and 0x104 (lines 32–63). Line n is bit n%32 of the register selected by n/32.
- R2: A write with 1 in a control bit asserts that line from the first cycle after the write edge.
- R3: A self-clearing line stays asserted for exactly PULSE_CYCLES cycles after its write, then deasserts by itself.
- R4: Writing 1 to a self-clearing line that is already active reloads its count to PULSE_CYCLES.
- R5: Writing 0 to a self-clearing line's bit has no effect, and a running pulse completes normally.
- R6: Lines 12 and 56 (HELD_MASK bits) stay asserted indefinitely after a 1 is written. A control write with 0 in their bit releases them on the next cycle.
- R7: `sys_rst_req_o` is high exactly while line 0 is asserted.
- R8: Status registers at 0x150 (lines 0–31) and 0x154 (lines 32–63) read 0 for an asserted line and 1 for a released line.
- R9: A read of a control register returns the current line states, active-high.
- R10: After `rst_ni` is asserted, all 64 lines are deasserted, control reads return 0, and status reads return all ones.
- R11: An unmapped offset reads 0. A write to an unmapped offset changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and pulse timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Read data for `addr_i` |
| rst_lines_o | output | NUM_REGS*REG_W | Reset outputs, active-high |
| sys_rst_req_o | output | 1 | System reset request |

## Verification
The bench builds the block with PULSE_CYCLES set to 6 and keeps the default held mask. The longer pulse leaves room to re-trigger a line mid-pulse, which exercises R4. It also leaves room to write 0 mid-pulse, which exercises R5, and to observe both before the count ends. The default mask places one held line in each register. Writes to either register therefore mix held and self-clearing bits, and an all-ones write checks both kinds together.

// File: rtl/reset_gen_pkg.sv
package reset_gen_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_STAT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rgu_addr_decode.sv
module rgu_addr_decode
  import reset_gen_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 2,
  parameter int CTRL_BASE = 'h100,
  parameter int STAT_BASE = 'h150,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    kind_o = ACC_NONE;
    idx_o  = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr_i == ADDR_W'(CTRL_BASE + 4 * k)) begin
        kind_o = ACC_CTRL;
        idx_o  = IDX_W'(k);
      end
      if (addr_i == ADDR_W'(STAT_BASE + 4 * k)) begin
        kind_o = ACC_STAT;
        idx_o  = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/rgu_pulse_line.sv
module rgu_pulse_line #(
  parameter int PULSE_CYCLES = 4,
  localparam int CNT_W       = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (set_i)        cnt_q <= CNT_W'(PULSE_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rgu_held_line.sv
module rgu_held_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic val_i,
  output logic active_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= 1'b0;
    else if (load_i) q <= val_i;
  end

  assign active_o = q;
endmodule

// File: rtl/reset_gen_unit.sv
module reset_gen_unit
  import reset_gen_pkg::*;
#(
  parameter int REG_W        = 32,
  parameter int NUM_REGS     = 2,
  parameter int ADDR_W       = 12,
  parameter int CTRL_BASE    = 'h100,
  parameter int STAT_BASE    = 'h150,
  parameter int PULSE_CYCLES = 4,
  parameter int SYS_LINE     = 0,
  parameter logic [NUM_REGS*REG_W-1:0] HELD_MASK = 64'h0100_0000_0000_1000,
  localparam int NUM_LINES   = NUM_REGS * REG_W,
  localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [NUM_LINES-1:0] rst_lines_o,
  output logic                 sys_rst_req_o
);
  acc_kind_e           kind;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] ctrl_we;
  logic [REG_W-1:0]    grp [NUM_REGS];

  rgu_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .CTRL_BASE(CTRL_BASE),
    .STAT_BASE(STAT_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .kind_o(kind),
    .idx_o (idx)
  );

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++)
      ctrl_we[k] = we_i && (kind == ACC_CTRL) && (idx == IDX_W'(k));
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int RK = n / REG_W;
    localparam int RB = n % REG_W;
    if (HELD_MASK[n]) begin : g_held
      rgu_held_line u_line (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (ctrl_we[RK]),
        .val_i   (wdata_i[RB]),
        .active_o(rst_lines_o[n])
      );
    end else begin : g_pulse
      rgu_pulse_line #(.PULSE_CYCLES(PULSE_CYCLES)) u_line (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (ctrl_we[RK] & wdata_i[RB]),
        .active_o(rst_lines_o[n])
      );
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_grp
    assign grp[k] = rst_lines_o[k*REG_W +: REG_W];
  end

  // status view is the inverted line state
  always_comb begin
    unique case (kind)
      ACC_CTRL: rdata_o = grp[idx];
      ACC_STAT: rdata_o = ~grp[idx];
      default:  rdata_o = '0;
    endcase
  end

  assign sys_rst_req_o = rst_lines_o[SYS_LINE];
endmodule

// File: rtl/rgu_checker.sv
module rgu_checker #(
  parameter int REG_W        = 32,
  parameter int NUM_REGS     = 2,
  parameter int ADDR_W       = 12,
  parameter int CTRL_BASE    = 'h100,
  parameter int STAT_BASE    = 'h150,
  parameter int SYS_LINE     = 0,
  parameter logic [NUM_REGS*REG_W-1:0] HELD_MASK = '0,
  localparam int NUM_LINES   = NUM_REGS * REG_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 we_i,
  input logic [REG_W-1:0]     wdata_i,
  input logic [REG_W-1:0]     rdata_o,
  input logic [NUM_LINES-1:0] rst_lines_o,
  input logic                 sys_rst_req_o
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int k = 0; k < NUM_REGS; k++)
      if (addr_i == ADDR_W'(CTRL_BASE + 4 * k) || addr_i == ADDR_W'(STAT_BASE + 4 * k))
        mapped = 1'b1;
  end

  p_sys_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o == rst_lines_o[SYS_LINE]);

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    p_status_inv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == ADDR_W'(STAT_BASE + 4 * k) |-> rdata_o == ~rst_lines_o[k*REG_W +: REG_W]);
    p_ctrl_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == ADDR_W'(CTRL_BASE + 4 * k) |-> rdata_o == rst_lines_o[k*REG_W +: REG_W]);
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
    localparam int RK = n / REG_W;
    localparam int RB = n % REG_W;
    p_assert_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == ADDR_W'(CTRL_BASE + 4 * RK) && wdata_i[RB] |=> rst_lines_o[n]);
    if (HELD_MASK[n]) begin : g_h
      p_held_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_lines_o[n] && !(we_i && addr_i == ADDR_W'(CTRL_BASE + 4 * RK)) |=> rst_lines_o[n]);
    end
  end
endmodule

bind reset_gen_unit rgu_checker #(
  .REG_W    (REG_W),
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W),
  .CTRL_BASE(CTRL_BASE),
  .STAT_BASE(STAT_BASE),
  .SYS_LINE (SYS_LINE),
  .HELD_MASK(HELD_MASK)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .rst_lines_o  (rst_lines_o),
  .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/reset_gen_unit_test.sv
module reset_gen_unit_test;
  localparam int P = 6;
  localparam logic [63:0] HM = 64'h0100_0000_0000_1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] rst_lines_o;
  logic        sys_rst_req_o;

  int checks = 0;
  int errors = 0;

  int cnt [64];
  bit hv  [64];

  always #4 clk_i = ~clk_i;

  reset_gen_unit #(.PULSE_CYCLES(P)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_lines_o(rst_lines_o),
    .sys_rst_req_o(sys_rst_req_o)
  );

  // behavioural reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < 64; n++) begin cnt[n] = 0; hv[n] = 0; end
    end else begin
      for (int n = 0; n < 64; n++) begin
        bit wr;
        wr = we_i && (addr_i == 12'(32'h100 + 4 * (n / 32)));
        if (HM[n]) begin
          if (wr) hv[n] = wdata_i[n % 32];
        end else if (wr && wdata_i[n % 32]) cnt[n] = P;
        else if (cnt[n] > 0) cnt[n] = cnt[n] - 1;
      end
    end
  end

  function automatic logic [63:0] exp_lines();
    logic [63:0] v;
    for (int n = 0; n < 64; n++) v[n] = HM[n] ? hv[n] : (cnt[n] > 0);
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    logic [63:0] l;
    l = exp_lines();
    case (a)
      12'h100: return l[31:0];
      12'h104: return l[63:32];
      12'h150: return ~l[31:0];
      12'h154: return ~l[63:32];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [11:0] a, logic w, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = w; wdata_i = d;
    #1;
    chk({tag, " lines"}, rst_lines_o, exp_lines());
    chk("R7 sys_req", 64'(sys_rst_req_o), 64'(exp_lines() & 64'h1));
    chk({tag, " rdata"}, 64'(rdata_o), 64'(exp_rd(a)));
  endtask

  task automatic idle(string tag, logic [11:0] a, int n);
    for (int i = 0; i < n; i++) step(tag, a, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R10 reset state
    step("R10", 12'h150, 0, 0);
    chk("R10 stat0", 64'(rdata_o), 64'hFFFF_FFFF);
    step("R10", 12'h154, 0, 0);
    chk("R10 stat1", 64'(rdata_o), 64'hFFFF_FFFF);
    step("R10", 12'h100, 0, 0);
    chk("R10 ctrl0", 64'(rdata_o), 64'h0);
    // R1 R2 mapping and assertion
    step("R1", 12'h100, 1, 32'h0000_0008);
    step("R2", 12'h100, 0, 0);
    chk("R2 line3", 64'(rst_lines_o[3]), 64'h1);
    step("R1", 12'h104, 1, 32'h0000_0004);
    step("R1", 12'h104, 0, 0);
    chk("R1 line34", 64'(rst_lines_o[34]), 64'h1);
    idle("R8", 12'h154, 3);
    idle("R9", 12'h104, 4);
    // R3 pulse length
    step("R3", 12'h100, 1, 32'h0000_0200);
    begin
      int hi = 0;
      for (int i = 0; i < P + 3; i++) begin
        step("R3", 12'h150, 0, 0);
        if (rst_lines_o[9]) hi++;
      end
      chk("R3 pulse length", 64'(hi), 64'(P));
    end
    // R4 restart
    step("R4", 12'h100, 1, 32'h0000_0020);
    idle("R4", 12'h100, 3);
    step("R4", 12'h100, 1, 32'h0000_0020);
    idle("R4", 12'h100, P - 1);
    chk("R4 still active", 64'(rst_lines_o[5]), 64'h1);
    idle("R4", 12'h100, 3);
    // R5 write zero ignored
    step("R5", 12'h100, 1, 32'h0000_0080);
    idle("R5", 12'h100, 1);
    step("R5", 12'h100, 1, 32'h0000_0000);
    idle("R5", 12'h100, 2);
    chk("R5 pulse continues", 64'(rst_lines_o[7]), 64'h1);
    idle("R5", 12'h150, P);
    // R6 held lines
    step("R6", 12'h100, 1, 32'h0000_1000);
    step("R6", 12'h104, 1, 32'h0100_0000);
    idle("R6", 12'h150, P + 5);
    chk("R6 line12 held", 64'(rst_lines_o[12]), 64'h1);
    chk("R6 line56 held", 64'(rst_lines_o[56]), 64'h1);
    step("R6", 12'h100, 1, 32'h0000_0000);
    step("R6", 12'h104, 1, 32'h0000_0000);
    step("R6", 12'h100, 0, 0);
    chk("R6 released", 64'(rst_lines_o[12] | rst_lines_o[56]), 64'h0);
    // R7 system line
    step("R7", 12'h100, 1, 32'h0000_0001);
    step("R7", 12'h100, 0, 0);
    chk("R7 req high", 64'(sys_rst_req_o), 64'h1);
    idle("R7", 12'h100, P + 1);
    chk("R7 req low", 64'(sys_rst_req_o), 64'h0);
    // R11 unmapped
    step("R11", 12'h108, 1, 32'hFFFF_FFFF);
    step("R11", 12'h000, 1, 32'hFFFF_FFFF);
    step("R11", 12'h158, 1, 32'hFFFF_FFFF);
    step("R11", 12'h10C, 0, 0);
    chk("R11 no lines", rst_lines_o, 64'h0);
    chk("R11 read zero", 64'(rdata_o), 64'h0);
    // mixed all-ones write
    step("R6", 12'h100, 1, 32'hFFFF_FFFF);
    step("R6", 12'h104, 1, 32'hFFFF_FFFF);
    idle("R8", 12'h150, P + 2);
    chk("R6 only held remain", rst_lines_o, HM);
    step("R6", 12'h104, 1, 32'h0);
    step("R6", 12'h100, 1, 32'h0);
    idle("R9", 12'h100, 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule